// File: doc/BRIEF.md
# Cross-Parity Protected Sample Delay Line

This block is the storage of a moving-average datapath: a shift line of `DEPTH` words, each `WIDTH` bits wide. Every strobed sample enters at the newest position and pushes the oldest word out to the subtract tap. The line keeps itself consistent against single-bit upsets with two independent parity sets. Each stored word carries one parity bit, computed from the sample when it enters. A column parity register holds one bit per bit position, covering all words in the line. The column parity is updated incrementally: each strobe folds in the entering word and the leaving word.

On every strobe, the block recomputes both parity sets from the stored words and compares them with the stored and accumulated bits. A word disagreement together with a column disagreement points at one data bit, which is flipped back. A lone disagreement of either kind means the parity bit itself was hit, and that bit is rewritten. The check and repair happen in the same cycle as the shift, before the oldest word is handed to the tap, so a single upset never reaches the output. A one-cycle flag reports each repair and whether it touched data or parity.

An upset port flips one chosen storage bit. It models radiation hits in a test environment.

Top module: `xpar_delay_line`

## Requirements
- R1: While reset is asserted and after its release, `out_vld`, `out_data`, `corr_evt` and `corr_kind` are zero, and all stored words and parity bits start at zero.
- R2: The cycle after each strobe (`in_vld`=1), `out_vld` is 1 and `out_data` holds the sample strobed `DEPTH` strobes earlier, or zero while fewer than `DEPTH` samples have entered. In cycles after no strobe, `out_vld` is 0 and `out_data` keeps its value.
- R3: Each entering word is stored with a word parity bit equal to the XOR of its bits. A later flip of that bit alone is seen as a word-parity fault.
- R4: The column parity is kept equal to the XOR of all stored words through every shift. After a strobe that starts from a state with at most one fault, both parity sets agree with the data.
- R5: A single flipped data bit is corrected in place at the next strobe, before the word can leave the line. `out_data` always shows the uncorrupted sample. The flag reports `corr_kind` = 2'b01 (bit 0 = data repaired).
- R6: A single flipped word parity bit is rewritten at the next strobe, with no change to data. The flag reports `corr_kind` = 2'b10 (bit 1 = parity repaired).
- R7: A single flipped column parity bit is rewritten at the next strobe, with no change to data. The flag reports `corr_kind` = 2'b10.
- R8: A strobe that finds no disagreement leaves the stored state unchanged apart from the shift, and raises no flag.
- R9: `corr_evt` is a one-cycle pulse that appears only in the cycle after a strobe. `corr_kind` is 2'b00 whenever `corr_evt` is 0.
- R10: The upset port acts only in a cycle without a strobe. `upset_kind` selects the target: 0 = data bit [`upset_row`][`upset_col`], 1 = word parity of `upset_row`, 2 = column parity bit `upset_col`, 3 = none. Row 0 is the newest word and row `DEPTH`-1 the oldest. An upset requested together with a strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Sample strobe |
| in_data | input | WIDTH | Sample entering the line |
| upset_en | input | 1 | Apply one bit flip this cycle |
| upset_kind | input | 2 | Upset target: 0 data, 1 word parity, 2 column parity, 3 none |
| upset_row | input | RW | Word index of the upset (0 newest) |
| upset_col | input | CW | Bit index of the upset |
| out_vld | output | 1 | Tap valid, one cycle after a strobe |
| out_data | output | WIDTH | Oldest word leaving the line, after repair |
| corr_evt | output | 1 | One-cycle repair pulse |
| corr_kind | output | 2 | Bit 0 data repaired, bit 1 parity repaired |

## Verification
Several properties are checked on every cycle:
- The strobe-to-tap timing holds.
- The tap holds its value between strobes.
- The repair flag only follows a strobe, and its kind field is clear when idle.
- The flag stays quiet when both syndromes are clean.
- Any strobe that starts with at most one fault leaves both parity sets fully consistent. This is the invariant that ties the incremental column update to the shift.

Other behaviours need directed upsets from the bench's scenarios. These are whether the right bit is located and flipped back, whether the oldest word is repaired before it is emitted, how each fault class is reported, and whether an upset that coincides with a strobe is ignored.

// File: rtl/xpar_pkg.sv
package xpar_pkg;
  typedef enum logic [1:0] {
    UPS_DATA = 2'd0,
    UPS_WPAR = 2'd1,
    UPS_CPAR = 2'd2,
    UPS_NONE = 2'd3
  } upset_kind_e;

  localparam int unsigned KIND_DATA_BIT = 0;
  localparam int unsigned KIND_PAR_BIT  = 1;
endpackage

// File: rtl/xpar_syndrome.sv
module xpar_syndrome #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] words,
  input  logic [DEPTH-1:0]            wpar,
  input  logic [WIDTH-1:0]            cpar,
  output logic [DEPTH-1:0]            word_err,
  output logic [WIDTH-1:0]            col_err
);
  // per-word recomputation
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign word_err[g] = (^words[g]) ^ wpar[g];
  end

  // per-column recomputation against the accumulated column parity
  always_comb begin
    col_err = cpar;
    for (int i = 0; i < DEPTH; i++) begin
      col_err = col_err ^ words[i];
    end
  end
endmodule

// File: rtl/xpar_locate.sv
module xpar_locate #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic [DEPTH-1:0] word_err,
  input  logic [WIDTH-1:0] col_err,
  output logic [DEPTH-1:0] row_mask,
  output logic [WIDTH-1:0] col_mask,
  output logic [DEPTH-1:0] wpar_flip,
  output logic [WIDTH-1:0] cpar_flip,
  output logic             fix_data,
  output logic             fix_par,
  output logic             fixable
);
  logic w_one, c_one, w_none, c_none, fix_wp, fix_cp;

  always_comb begin
    w_one  = $onehot(word_err);
    c_one  = $onehot(col_err);
    w_none = (word_err == '0);
    c_none = (col_err == '0);

    fix_data = w_one && c_one;
    fix_wp   = w_one && c_none;
    fix_cp   = w_none && c_one;

    row_mask  = fix_data ? word_err : '0;
    col_mask  = fix_data ? col_err  : '0;
    wpar_flip = fix_wp   ? word_err : '0;
    cpar_flip = fix_cp   ? col_err  : '0;

    fix_par = fix_wp || fix_cp;
    fixable = fix_data || fix_par || (w_none && c_none);
  end
endmodule

// File: rtl/xpar_delay_line.sv
module xpar_delay_line
  import xpar_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int WIDTH = 8,
  localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_data,
  input  logic             upset_en,
  input  logic [1:0]       upset_kind,
  input  logic [RW-1:0]    upset_row,
  input  logic [CW-1:0]    upset_col,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_data,
  output logic             corr_evt,
  output logic [1:0]       corr_kind
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // state
  logic [DEPTH-1:0][WIDTH-1:0] words_q, words_n, words_f;
  logic [DEPTH-1:0]            wpar_q, wpar_n, wpar_f;
  logic [WIDTH-1:0]            cpar_q, cpar_n, cpar_f;
  logic [WIDTH-1:0]            tap_q, tap_n;
  logic                        ovld_q, ovld_n;
  logic                        evt_q, evt_n;
  logic [1:0]                  kind_q, kind_n;

  // syndrome and fault location
  logic [DEPTH-1:0] word_err, row_mask, wpar_flip;
  logic [WIDTH-1:0] col_err, col_mask, cpar_flip;
  logic             fix_data, fix_par, fixable;

  xpar_syndrome #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_syn (
    .words   (words_q),
    .wpar    (wpar_q),
    .cpar    (cpar_q),
    .word_err(word_err),
    .col_err (col_err)
  );

  xpar_locate #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_loc (
    .word_err (word_err),
    .col_err  (col_err),
    .row_mask (row_mask),
    .col_mask (col_mask),
    .wpar_flip(wpar_flip),
    .cpar_flip(cpar_flip),
    .fix_data (fix_data),
    .fix_par  (fix_par),
    .fixable  (fixable)
  );

  // repaired view of the state, used by the shift
  for (genvar g = 0; g < DEPTH; g++) begin : g_fix
    assign words_f[g] = words_q[g] ^ ({WIDTH{row_mask[g]}} & col_mask);
  end
  assign wpar_f = wpar_q ^ wpar_flip;
  assign cpar_f = cpar_q ^ cpar_flip;

  // next state
  always_comb begin
    words_n = words_q;
    wpar_n  = wpar_q;
    cpar_n  = cpar_q;
    tap_n   = tap_q;
    ovld_n  = 1'b0;
    evt_n   = 1'b0;
    kind_n  = 2'b00;
    if (in_vld) begin
      words_n[0] = in_data;
      wpar_n[0]  = ^in_data;
      for (int i = 1; i < DEPTH; i++) begin
        words_n[i] = words_f[i-1];
        wpar_n[i]  = wpar_f[i-1];
      end
      cpar_n = cpar_f ^ in_data ^ words_f[DEPTH-1];
      tap_n  = words_f[DEPTH-1];
      ovld_n = 1'b1;
      kind_n[KIND_DATA_BIT] = fix_data;
      kind_n[KIND_PAR_BIT]  = fix_par;
      evt_n  = fix_data || fix_par;
    end else if (upset_en) begin
      unique case (upset_kind_e'(upset_kind))
        UPS_DATA: if (32'(upset_row) < DEPTH && 32'(upset_col) < WIDTH)
                    words_n[upset_row][upset_col] = ~words_q[upset_row][upset_col];
        UPS_WPAR: if (32'(upset_row) < DEPTH)
                    wpar_n[upset_row] = ~wpar_q[upset_row];
        UPS_CPAR: if (32'(upset_col) < WIDTH)
                    cpar_n[upset_col] = ~cpar_q[upset_col];
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      words_q <= '0;
      wpar_q  <= '0;
      cpar_q  <= '0;
      tap_q   <= '0;
      ovld_q  <= 1'b0;
      evt_q   <= 1'b0;
      kind_q  <= 2'b00;
    end else begin
      words_q <= words_n;
      wpar_q  <= wpar_n;
      cpar_q  <= cpar_n;
      tap_q   <= tap_n;
      ovld_q  <= ovld_n;
      evt_q   <= evt_n;
      kind_q  <= kind_n;
    end
  end

  assign out_vld   = ovld_q;
  assign out_data  = tap_q;
  assign corr_evt  = evt_q;
  assign corr_kind = kind_q;

  // R2
  strobe_tap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_vld |=> out_vld);

  // R2
  idle_tap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !in_vld |=> (!out_vld && $stable(out_data)));

  // R4
  consistent_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_vld && fixable) |=> (word_err == '0 && col_err == '0));

  // R8
  quiet_when_clean_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_vld && word_err == '0 && col_err == '0) |=> !corr_evt);

  // R9
  flag_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    corr_evt |-> $past(in_vld));

  // R9
  kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !corr_evt |-> corr_kind == 2'b00);
endmodule

// File: tb/test_xpar_delay_line.sv
`timescale 1ns/1ps
module test_xpar_delay_line;
  localparam int N = 8;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, in_vld, upset_en;
  logic [W-1:0] in_data;
  logic [1:0]   upset_kind;
  logic [2:0]   upset_row, upset_col;
  logic         out_vld, corr_evt;
  logic [W-1:0] out_data;
  logic [1:0]   corr_kind;

  xpar_delay_line #(.DEPTH(N), .WIDTH(W)) i_xpar_delay_line (
    .clk, .rst_n, .in_vld, .in_data, .upset_en, .upset_kind,
    .upset_row, .upset_col, .out_vld, .out_data, .corr_evt, .corr_kind
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] hist [64];
  int cnt = 0;

  // {upset kind, row, col, sample, expected corr_kind}; kind 3 = none
  localparam logic [17:0] VEC [16] = '{
    {2'd3, 3'd0, 3'd0, 8'h3C, 2'd0},
    {2'd3, 3'd0, 3'd0, 8'hA5, 2'd0},
    {2'd0, 3'd1, 3'd2, 8'h5A, 2'd1},
    {2'd1, 3'd4, 3'd0, 8'h96, 2'd2},
    {2'd2, 3'd0, 3'd7, 8'hC3, 2'd2},
    {2'd3, 3'd0, 3'd0, 8'h0F, 2'd0},
    {2'd3, 3'd0, 3'd0, 8'hF0, 2'd0},
    {2'd3, 3'd0, 3'd0, 8'h81, 2'd0},
    {2'd0, 3'd7, 3'd0, 8'h7E, 2'd1},
    {2'd0, 3'd3, 3'd6, 8'h18, 2'd1},
    {2'd3, 3'd0, 3'd0, 8'hE7, 2'd0},
    {2'd1, 3'd7, 3'd0, 8'h24, 2'd2},
    {2'd2, 3'd0, 3'd0, 8'hDB, 2'd2},
    {2'd0, 3'd0, 3'd7, 8'h42, 2'd1},
    {2'd3, 3'd0, 3'd0, 8'hBD, 2'd0},
    {2'd3, 3'd0, 3'd0, 8'h66, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic upset(input logic [1:0] k, input logic [2:0] r, input logic [2:0] c);
    @(negedge clk);
    upset_en = 1'b1; upset_kind = k; upset_row = r; upset_col = c;
    @(negedge clk);
    upset_en = 1'b0; upset_kind = 2'd3;
  endtask

  // strobe one sample, optionally with a simultaneous upset request (R10)
  task automatic strobe(input logic [W-1:0] s, input logic [1:0] exp_kind, input bit with_upset);
    logic [W-1:0] exp_out;
    @(negedge clk);
    in_vld = 1'b1; in_data = s;
    if (with_upset) begin
      upset_en = 1'b1; upset_kind = 2'd0; upset_row = 3'd7; upset_col = 3'd3;
    end
    @(negedge clk);
    in_vld = 1'b0; upset_en = 1'b0; upset_kind = 2'd3;
    exp_out = (cnt >= N) ? hist[cnt-N] : '0;
    hist[cnt] = s;
    cnt++;
    chk("R2 out_vld after strobe", 32'(out_vld), 32'd1);
    chk("R5 R2 out_data", 32'(out_data), 32'(exp_out));
    chk("R5 R6 R7 R8 corr_evt", 32'(corr_evt), 32'(exp_kind != 2'd0));
    chk("R5 R6 R7 R8 corr_kind", 32'(corr_kind), 32'(exp_kind));
    @(negedge clk);
    chk("R9 corr_evt pulse ended", 32'(corr_evt), 32'd0);
    chk("R2 out_vld idle", 32'(out_vld), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0;
    upset_en = 1'b0; upset_kind = 2'd3; upset_row = '0; upset_col = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_vld in reset", 32'(out_vld), 32'd0);
    chk("R1 out_data in reset", 32'(out_data), 32'd0);
    chk("R1 corr_evt in reset", 32'(corr_evt), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 corr_kind after release", 32'(corr_kind), 32'd0);
    chk("R1 out_data after release", 32'(out_data), 32'd0);

    // vector table: R2..R9
    for (int v = 0; v < 16; v++) begin
      if (VEC[v][17:16] != 2'd3) upset(VEC[v][17:16], VEC[v][15:13], VEC[v][12:10]);
      strobe(VEC[v][9:2], VEC[v][1:0], 1'b0);
    end

    // R10: upset alongside a strobe is ignored; the next strobe finds a clean line
    strobe(8'h99, 2'd0, 1'b1);
    strobe(8'h11, 2'd0, 1'b0);

    // R3: parity of a freshly entered word, flipped alone, is a parity fault
    upset(2'd1, 3'd0, 3'd0);
    strobe(8'h77, 2'd2, 1'b0);

    // R5: two successive single faults, each repaired, then drained out unharmed
    upset(2'd0, 3'd5, 3'd4);
    strobe(8'hC8, 2'd1, 1'b0);
    upset(2'd0, 3'd6, 3'd1);
    strobe(8'h3E, 2'd1, 1'b0);
    for (int d = 0; d < N; d++) strobe(8'(8'h20 + d), 2'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule